// File: doc/BRIEF.md
# Oversampling Biphase-Mark Audio Receiver Front End

This block turns a serial S/PDIF line into parallel audio samples. The line is already synchronised to one fixed, free-running fast clock, and no clock is locked to the incoming stream. Every transition of the line is time-stamped by counting fast-clock cycles. The width of each constant-level pulse is the basis of every decision.

After reset, or after the line goes quiet, the block first estimates the bit-cell width. The estimate is the narrowest pulse seen over a fixed number of measured transitions. It then classifies each pulse as one, two or three cells wide, with decision points at one and a half, two and a half and three and a half estimated cells after the transition that opened the pulse. Because it re-estimates after every loss of signal, it follows whatever sample rate arrives, provided the cell spans at least a few fast-clock cycles.

Three-cell pulses mark preambles and give the frame alignment. The block then rebuilds each 28-slot payload. For every subframe it presents one 24-bit signed audio word and the four per-subframe flag bits, with:
- a parity-error indication;
- a left/right channel index;
- a block-start indication;
- a single-cycle strobe.

Top module: `spdif_rx_front`

## Requirements
- R1: While and right after reset, `locked` and `smp_stb` are 0.
- R2: While unlocked, each transition whose pulse was shorter than the counter maximum is counted. The narrowest such pulse becomes the cell estimate. `locked` rises after EST_EDGES counted transitions, and the estimate stays constant while locked.
- R3: A pulse of width w, with estimate c, is classed as one cell when 2w < 3c, two cells when 2w < 5c, and three cells when 2w < 7c. Widths of ±1 fast-clock period around the nominal values decode correctly.
- R4: A preamble is a three-cell pulse followed by pulses totalling 8 cells. The order 3,1,1,3 gives `smp_blk`=1 and `smp_right`=0. The order 3,3,1,1 gives `smp_blk`=0 and `smp_right`=0. The order 3,2,1,2 gives `smp_right`=1 and `smp_blk`=0.
- R5: After a preamble, a pair of one-cell pulses decodes as bit 1, and a single two-cell pulse decodes as bit 0.
- R6: Payload slot k is the k-th decoded bit plus 4. `smp_word[0]` is slot 4 and `smp_word[23]` is slot 27, so the word is a signed two's-complement value.
- R7: `smp_valid`, `smp_user`, `smp_cstat` and `smp_parity` carry slots 28, 29, 30 and 31 of the same subframe.
- R8: `smp_perr` is 1 when the number of ones over slots 4 to 31 is odd. The word and the flags are still presented.
- R9: `smp_stb` is high for exactly one cycle per complete subframe, and only while locked. Each subframe that begins after lock yields exactly one strobe, in stream order.
- R10: When the line has no transition for longer than three and a half estimated cells, `locked` falls and no strobe occurs until a new lock.
- R11: After losing lock, the block locks again at a different cell width and decodes that stream correctly.
- R12: A two-cell pulse that follows a lone one-cell pulse abandons the subframe: it yields no strobe, and the next preamble decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdin | input | 1 | Serial biphase-mark line, synchronous to clk |
| locked | output | 1 | Cell estimate valid, decoding enabled |
| smp_stb | output | 1 | One-cycle strobe, a new subframe is on the outputs |
| smp_word | output | 24 | Signed audio word, MSB at bit 23 |
| smp_right | output | 1 | Subframe is the second channel |
| smp_blk | output | 1 | Subframe opens a new block |
| smp_valid | output | 1 | Validity flag (slot 28) |
| smp_user | output | 1 | User bit (slot 29) |
| smp_cstat | output | 1 | Channel-status bit (slot 30) |
| smp_parity | output | 1 | Received parity bit (slot 31) |
| smp_perr | output | 1 | Odd parity over slots 4 to 31 |

## Verification
A wrong cell estimate misclassifies pulses, and the effect shows within the next subframe. Either a whole subframe goes missing from the strobe sequence, or it arrives with a shifted word, or the lock flag drops on a legal three-cell pulse. A fault in preamble tracking shows up as a channel or block indication that is wrong on the very next strobe. A slot counter that is off by one moves the flag bits into the word, or the word into the flags, which is visible on the same strobe. A faulty loss detector shows within a few cells of silence, as a lock flag that stays high.

// File: rtl/spdif_rx_pkg.sv
`timescale 1ns/1ps
package spdif_rx_pkg;

  localparam int AUDIO_W   = 24;
  localparam int PAYLOAD_W = 28;

  typedef enum logic [1:0] {PW_SHORT, PW_LONG, PW_TRIPLE, PW_BAD} pw_e;

  // pulse width w against cell estimate c, decisions at 1.5 / 2.5 / 3.5 cells
  function automatic pw_e classify_pulse(input logic [15:0] w, input logic [15:0] c);
    logic [18:0] w2, c1;
    w2 = {2'b00, w, 1'b0};
    c1 = {3'b000, c};
    if (w2 < c1 * 19'd3)      return PW_SHORT;
    else if (w2 < c1 * 19'd5) return PW_LONG;
    else if (w2 < c1 * 19'd7) return PW_TRIPLE;
    else                      return PW_BAD;
  endfunction

  function automatic logic [2:0] pw_cells(input pw_e p);
    case (p)
      PW_SHORT:  return 3'd1;
      PW_LONG:   return 3'd2;
      PW_TRIPLE: return 3'd3;
      default:   return 3'd0;
    endcase
  endfunction

  // true when a run has outlasted 3.5 cells
  function automatic logic beyond_window(input logic [15:0] w, input logic [15:0] c);
    return ({2'b00, w, 1'b0} > {3'b000, c} * 19'd7);
  endfunction

endpackage

// File: rtl/spdif_edge_meter.sv
`timescale 1ns/1ps
module spdif_edge_meter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdin,
  output logic          edge_o,
  output logic [CW-1:0] pulse_w,
  output logic [CW-1:0] run_cnt
);
  localparam logic [CW-1:0] MAXW = {CW{1'b1}};

  logic          prev;
  logic [CW-1:0] cnt;

  assign edge_o  = sdin ^ prev;
  assign pulse_w = cnt;
  assign run_cnt = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      cnt  <= MAXW;
    end else begin
      prev <= sdin;
      if (edge_o)           cnt <= {{(CW-1){1'b0}}, 1'b1};
      else if (cnt != MAXW) cnt <= cnt + 1'b1;
    end
  end

  assert_count_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (run_cnt == {{(CW-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/spdif_rate_est.sv
`timescale 1ns/1ps
module spdif_rate_est
  import spdif_rx_pkg::*;
#(
  parameter int CW        = 8,
  parameter int EST_EDGES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic [CW-1:0] pulse_w,
  input  logic [CW-1:0] run_cnt,
  output logic          locked,
  output logic [CW-1:0] cell_w,
  output logic          timeout_o
);
  localparam int NW = $clog2(EST_EDGES + 1);
  localparam logic [CW-1:0] MAXW = {CW{1'b1}};
  localparam logic [NW-1:0] LAST = NW'(EST_EDGES - 1);

  logic [NW-1:0] n_edges;

  assign timeout_o = locked && beyond_window(16'(run_cnt), 16'(cell_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      cell_w  <= MAXW;
      n_edges <= '0;
    end else if (!locked) begin
      if (edge_i && pulse_w != MAXW) begin
        if (pulse_w < cell_w) cell_w <= pulse_w;
        if (n_edges == LAST) locked <= 1'b1;
        n_edges <= n_edges + 1'b1;
      end
    end else if (timeout_o) begin
      locked  <= 1'b0;
      cell_w  <= MAXW;
      n_edges <= '0;
    end
  end

  assert_cell_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(cell_w));
  assert_lock_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (cell_w != MAXW));
  assert_loss_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !locked);

endmodule

// File: rtl/spdif_frame_dec.sv
`timescale 1ns/1ps
module spdif_frame_dec
  import spdif_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_i,
  input  logic               edge_i,
  input  pw_e                cls_i,
  output logic               smp_stb,
  output logic [AUDIO_W-1:0] smp_word,
  output logic               smp_right,
  output logic               smp_blk,
  output logic               smp_valid,
  output logic               smp_user,
  output logic               smp_cstat,
  output logic               smp_parity,
  output logic               smp_perr
);
  typedef enum logic [1:0] {S_HUNT, S_PRE, S_DATA} st_e;

  st_e                  st;
  logic [3:0]           acc, nacc;
  logic [1:0]           pidx;
  logic                 k_right, k_blk, half;
  logic [4:0]           nbits;
  logic [PAYLOAD_W-1:0] sh, nsh;
  logic [2:0]           len;
  logic                 bit_done, bit_val, bit_bad;

  always_comb begin
    len      = pw_cells(cls_i);
    nacc     = acc + {1'b0, len};
    bit_done = 1'b0;
    bit_val  = 1'b0;
    bit_bad  = 1'b0;
    case (cls_i)
      PW_SHORT: if (half) begin bit_done = 1'b1; bit_val = 1'b1; end
      PW_LONG:  if (half) bit_bad = 1'b1; else bit_done = 1'b1;
      default:  bit_bad = 1'b1;
    endcase
    nsh = {bit_val, sh[PAYLOAD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HUNT; acc <= '0; pidx <= '0; k_right <= 1'b0; k_blk <= 1'b0;
      half <= 1'b0; nbits <= '0; sh <= '0;
      smp_stb <= 1'b0; smp_word <= '0; smp_right <= 1'b0; smp_blk <= 1'b0;
      smp_valid <= 1'b0; smp_user <= 1'b0; smp_cstat <= 1'b0;
      smp_parity <= 1'b0; smp_perr <= 1'b0;
    end else begin
      smp_stb <= 1'b0;
      if (!lock_i) begin
        st <= S_HUNT;
      end else if (edge_i) begin
        if (cls_i == PW_TRIPLE && st != S_PRE) begin
          st <= S_PRE; acc <= 4'd3; pidx <= 2'd1;
        end else begin
          case (st)
            S_PRE: begin
              if (len == 3'd0 || nacc > 4'd8) begin
                st <= S_HUNT;
              end else begin
                if (pidx == 2'd1) begin
                  k_blk   <= (len == 3'd1);
                  k_right <= (len == 3'd2);
                end
                if (nacc == 4'd8) begin
                  st <= S_DATA; nbits <= '0; half <= 1'b0;
                end else begin
                  acc <= nacc; pidx <= pidx + 1'b1;
                end
              end
            end
            S_DATA: begin
              if (bit_bad) begin
                st <= S_HUNT;
              end else if (bit_done) begin
                sh   <= nsh;
                half <= 1'b0;
                if (nbits == 5'(PAYLOAD_W - 1)) begin
                  smp_stb    <= 1'b1;
                  smp_word   <= nsh[AUDIO_W-1:0];
                  smp_valid  <= nsh[24];
                  smp_user   <= nsh[25];
                  smp_cstat  <= nsh[26];
                  smp_parity <= nsh[27];
                  smp_perr   <= ^nsh;
                  smp_right  <= k_right;
                  smp_blk    <= k_blk;
                  st         <= S_HUNT;
                end else begin
                  nbits <= nbits + 1'b1;
                end
              end else begin
                half <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_stb_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> $past(lock_i));
  assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
  assert_one_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> !(smp_right && smp_blk));
  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nbits < 5'(PAYLOAD_W));

endmodule

// File: rtl/spdif_rx_front.sv
`timescale 1ns/1ps
module spdif_rx_front
  import spdif_rx_pkg::*;
#(
  parameter int CW        = 8,
  parameter int EST_EDGES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sdin,
  output logic        locked,
  output logic        smp_stb,
  output logic [23:0] smp_word,
  output logic        smp_right,
  output logic        smp_blk,
  output logic        smp_valid,
  output logic        smp_user,
  output logic        smp_cstat,
  output logic        smp_parity,
  output logic        smp_perr
);
  logic          edge_w, timeout_w;
  logic [CW-1:0] pulse_w, run_cnt, cell_w;
  pw_e           cls_w;

  spdif_edge_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .sdin(sdin),
    .edge_o(edge_w), .pulse_w(pulse_w), .run_cnt(run_cnt));

  spdif_rate_est #(.CW(CW), .EST_EDGES(EST_EDGES)) u_rate (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .pulse_w(pulse_w),
    .run_cnt(run_cnt), .locked(locked), .cell_w(cell_w), .timeout_o(timeout_w));

  assign cls_w = classify_pulse(16'(pulse_w), 16'(cell_w));

  spdif_frame_dec u_dec (
    .clk(clk), .rst_n(rst_n), .lock_i(locked), .edge_i(edge_w), .cls_i(cls_w),
    .smp_stb(smp_stb), .smp_word(smp_word), .smp_right(smp_right),
    .smp_blk(smp_blk), .smp_valid(smp_valid), .smp_user(smp_user),
    .smp_cstat(smp_cstat), .smp_parity(smp_parity), .smp_perr(smp_perr));

  assert_silence_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> !smp_stb);

endmodule

// File: tb/tb_spdif_rx_front.sv
`timescale 1ns/1ps
module tb_spdif_rx_front;
  logic clk = 1'b0, rst_n = 1'b0, sdin = 1'b0;
  logic locked, smp_stb, smp_right, smp_blk, smp_valid, smp_user, smp_cstat, smp_parity, smp_perr;
  logic [23:0] smp_word;

  always #2.5 clk = ~clk;

  spdif_rx_front dut (.*);

  typedef struct packed {
    logic [23:0] word;
    logic right, blk, v, u, c, p, err;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0, pushed = 0, rcvd = 0;
  int ui = 8, jit = 0;
  bit jit_en = 0, done = 0;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic run(input int n);
    int h;
    h = n * ui + (jit_en ? jit : 0);
    if (jit_en) jit = (jit == 1) ? -1 : jit + 1;
    sdin = ~sdin;
    repeat (h) @(negedge clk);
  endtask

  // kind: 0 block start (3,1,1,3), 1 first channel (3,3,1,1), 2 second channel (3,2,1,2)
  task automatic send_sub(input int kind, input logic [23:0] w, input logic v, u, c,
                          input bit badpar, input bit corrupt);
    logic [27:0] pl;
    item_t it;
    bit take;
    pl = {(^{c, u, v, w}) ^ badpar, c, u, v, w};
    run(3);
    take = locked && !corrupt;
    case (kind)
      0: begin run(1); run(1); run(3); end
      1: begin run(3); run(1); run(1); end
      default: begin run(2); run(1); run(2); end
    endcase
    for (int i = 0; i < 28; i++) begin
      if (corrupt && i == 10) begin run(1); run(2); end
      else if (pl[i]) begin run(1); run(1); end
      else run(2);
    end
    if (take) begin
      it = '{word: w, right: (kind == 2), blk: (kind == 0), v: v, u: u, c: c,
             p: pl[27], err: badpar};
      exp_q.push_back(it);
      pushed++;
    end
  endtask

  // monitor / scoreboard
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_n && smp_stb) begin
        rcvd++;
        if (exp_q.size() == 0) begin
          check(0, $sformatf("R9 unexpected strobe act word %h exp none", smp_word));
        end else begin
          e = exp_q.pop_front();
          check(smp_word == e.word, $sformatf("R5 R6 word act %h exp %h", smp_word, e.word));
          check({smp_right, smp_blk} == {e.right, e.blk},
                $sformatf("R4 right/blk act %b%b exp %b%b", smp_right, smp_blk, e.right, e.blk));
          check({smp_valid, smp_user, smp_cstat, smp_parity} == {e.v, e.u, e.c, e.p},
                $sformatf("R7 flags act %b%b%b%b exp %b%b%b%b", smp_valid, smp_user,
                          smp_cstat, smp_parity, e.v, e.u, e.c, e.p));
          check(smp_perr == e.err, $sformatf("R8 perr act %b exp %b", smp_perr, e.err));
        end
      end
    end
  end

  task automatic stream(input int base);
    logic [23:0] w;
    for (int k = 0; k < 6; k++) send_sub(k % 3, 24'h0, 1'b0, 1'b0, 1'b0, 0, 0);
    check(locked == 1'b1, $sformatf("R2 lock after warm-up act %b exp 1", locked));
    send_sub(0, 24'h800000, 1'b1, 1'b0, 1'b1, 0, 0);
    send_sub(2, 24'h7FFFFF, 1'b0, 1'b1, 1'b0, 0, 0);
    send_sub(1, 24'h000001, 1'b1, 1'b1, 1'b1, 0, 0);
    send_sub(2, 24'hA5C3E1, 1'b0, 1'b0, 1'b1, 1, 0);   // R8 bad parity
    send_sub(1, 24'h123456, 1'b1, 1'b0, 1'b0, 0, 1);   // R12 corrupted, dropped
    send_sub(2, 24'hFEDCBA, 1'b0, 1'b1, 1'b1, 0, 0);   // R12 recovery
    for (int k = 0; k < 6; k++) begin
      w = 24'((base + k) * 24'h2F1D3B) ^ 24'h5A5A5A;
      send_sub(k % 3, w, w[0], w[5], w[9], (k == 4), 0);
    end
    sdin = ~sdin;                                      // closes the last subframe
    repeat (200) @(negedge clk);
    check(locked == 1'b0, $sformatf("R10 lock after silence act %b exp 0", locked));
    check(exp_q.size() == 0, $sformatf("R9 R12 pending items act %0d exp 0", exp_q.size()));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(locked == 1'b0 && smp_stb == 1'b0,
          $sformatf("R1 reset state act %b%b exp 00", locked, smp_stb));
    rst_n = 1'b1;
    @(negedge clk);
    check(locked == 1'b0 && smp_stb == 1'b0,
          $sformatf("R1 after reset act %b%b exp 00", locked, smp_stb));
    ui = 8; jit_en = 0;
    stream(1);
    ui = 12; jit_en = 1;                               // R3 R11 new rate with jitter
    stream(7);
    check(pushed >= 20 && rcvd == pushed,
          $sformatf("R11 R9 strobes act %0d exp %0d", rcvd, pushed));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired R9 act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule